// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel of an 8-bit timer. Each enabled timer tick, it checks the running count against an active compare value. On a hit it raises a sticky match flag and updates a waveform pin. What the pin does on a hit (hold, toggle, clear or set) is chosen by a two-bit output action select. The counter sits outside the block. It provides the count, top and bottom markers, and a strobe that marks a software write to the count.

The compare value takes its software writes in one of two ways, depending on the waveform mode. In the two non-PWM modes a write lands in the active compare register at once. In the two PWM modes a write goes into a shadow register. The active value is then reloaded from the shadow only at the counter's top or bottom, which keeps pulse widths whole.

Software can also force a compare in the non-PWM modes. This drives the pin but leaves the flag alone. A write to the counter suppresses the match on the following tick, so a compare value equal to the freshly written count raises nothing.

Top module: `tcmp_channel`

## Requirements
- R1: After reset the flag is 0, the pin is 0, and both the active and the shadow compare values are 0.
- R2: In a cycle with tick_en high, cnt_val equal to the active compare value, and no pending block, a match occurs. The flag reads 1 after the next rising clock edge.
- R3: On a match, out_mode selects the pin action: 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0, 11 drives it to 1. The pin changes at the same edge as the flag.
- R4: In wave_mode 00 (normal) or 01 (clear on compare), a compare write becomes the active value at the next edge.
- R5: In wave_mode 10 a compare write only fills the shadow, which is copied to the active value on a tick with cnt_top high. In wave_mode 11 the copy happens on a tick with cnt_bottom high instead.
- R6: In wave_modes 00 and 01, a force_stb pulse applies the out_mode pin action and never sets the flag. If it coincides with a real match, the action is applied once.
- R7: In wave_modes 10 and 11, force_stb has no effect on the pin or the flag.
- R8: A cnt_wr pulse suppresses any match in the first tick-enabled cycle after it, however many cycles pass without a tick. Later ticks match normally.
- R9: The flag stays set until flag_clr or irq_ack is high. If a clear and a match fall in the same cycle, the flag stays set.
- R10: No match occurs in a cycle with tick_en low, even when cnt_val equals the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable for this cycle |
| cnt_val | input | 8 | Current counter value |
| cnt_top | input | 1 | Counter is at top |
| cnt_bottom | input | 1 | Counter is at bottom |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| cmp_wr | input | 1 | Software compare write strobe |
| cmp_wdata | input | 8 | Compare write data |
| force_stb | input | 1 | Force-compare strobe |
| wave_mode | input | 2 | 00 normal, 01 clear on compare, 10 PWM reload at top, 11 PWM reload at bottom |
| out_mode | input | 2 | Pin action on a match |
| flag_clr | input | 1 | Software write-one-to-clear of the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cmp_flag | output | 1 | Sticky match flag |
| wave_out | output | 1 | Waveform pin |

## Verification
The hardest case to reach is a counter write followed by a long stretch with the tick stopped. In that case the block must still remember that one tick's match is owed a suppression. The stimulus writes the counter, holds tick_en low for several cycles, and then presents a matching count on two successive ticks: the first must stay silent and the second must fire. The PWM shadow path is reached by writing a value that is not the active one, confirming a match on it stays absent, and then producing the top or bottom tick that copies it over.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL  = 2'b00,
    WM_CTC     = 2'b01,
    WM_PWM_TOP = 2'b10,
    WM_PWM_BOT = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    PA_HOLD   = 2'b00,
    PA_TOGGLE = 2'b01,
    PA_CLEAR  = 2'b10,
    PA_SET    = 2'b11
  } pin_act_e;

  function automatic logic mode_is_pwm(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic reload_due(input logic [1:0] mode, input logic top, input logic bottom);
    case (wave_mode_e'(mode))
      WM_PWM_TOP: return top;
      WM_PWM_BOT: return bottom;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic pin_apply(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      PA_TOGGLE: return ~cur;
      PA_CLEAR:  return 1'b0;
      PA_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/tcmp_cmpreg.sv
module tcmp_cmpreg
  import tcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [1:0]   wave_mode,
  input  logic         cnt_top,
  input  logic         cnt_bottom,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_act
);
  logic [W-1:0] shadow_q;
  logic         pwm;
  logic         reload_evt;

  assign pwm        = mode_is_pwm(wave_mode);
  assign reload_evt = pwm && tick_en && reload_due(wave_mode, cnt_top, cnt_bottom);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cmp_act  <= '0;
    end else begin
      if (wr_en) begin
        shadow_q <= wr_data;
        if (!pwm) cmp_act <= wr_data;
      end
      if (reload_evt) cmp_act <= shadow_q;
    end
  end

  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !reload_evt) |=> $stable(cmp_act)); // R5
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_act,
  output logic         match_evt,
  output logic         blk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       blk_q <= 1'b0;
    else if (cnt_wr)  blk_q <= 1'b1;
    else if (tick_en) blk_q <= 1'b0;
  end

  assign match_evt = tick_en && !blk_q && (cnt_val == cmp_act);

  AST_BLOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !tick_en) |=> blk_q); // R8
endmodule

// File: rtl/tcmp_wave.sv
module tcmp_wave
  import tcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wave_mode,
  input  logic [1:0] out_mode,
  input  logic       match_evt,
  input  logic       force_stb,
  output logic       wave_out
);
  logic force_ok;
  logic act_evt;

  assign force_ok = force_stb && !mode_is_pwm(wave_mode);
  assign act_evt  = match_evt || force_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)       wave_out <= 1'b0;
    else if (act_evt) wave_out <= pin_apply(out_mode, wave_out);
  end

  AST_HOLD_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |=> $stable(wave_out)); // R3
  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && mode_is_pwm(wave_mode) && !match_evt) |=> $stable(wave_out)); // R7
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_top,
  input  logic         cnt_bottom,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         force_stb,
  input  logic [1:0]   wave_mode,
  input  logic [1:0]   out_mode,
  input  logic         flag_clr,
  input  logic         irq_ack,
  output logic         cmp_flag,
  output logic         wave_out
);
  logic [W-1:0] cmp_act;
  logic         match_evt;
  logic         blk_q;
  logic         clr_evt;

  tcmp_cmpreg #(.W(W)) u_cmpreg (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wave_mode(wave_mode),
    .cnt_top(cnt_top), .cnt_bottom(cnt_bottom), .wr_en(cmp_wr),
    .wr_data(cmp_wdata), .cmp_act(cmp_act)
  );

  tcmp_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .cnt_val(cnt_val), .cmp_act(cmp_act), .match_evt(match_evt), .blk_q(blk_q)
  );

  tcmp_wave u_wave (
    .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .out_mode(out_mode),
    .match_evt(match_evt), .force_stb(force_stb), .wave_out(wave_out)
  );

  assign clr_evt = flag_clr || irq_ack;

  always_ff @(posedge clk) begin
    if (!rst_n)         cmp_flag <= 1'b0;
    else if (match_evt) cmp_flag <= 1'b1;
    else if (clr_evt)   cmp_flag <= 1'b0;
  end

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag); // R2
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !match_evt && !cmp_flag) |=> !cmp_flag); // R6
  AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick_en && !cmp_flag) |=> !cmp_flag); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !match_evt) |=> !cmp_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !clr_evt) |=> cmp_flag); // R9
  AST_NO_TICK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cmp_flag) |=> !cmp_flag); // R10
endmodule

// File: tb/tcmp_channel_tb_top.sv
module tcmp_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [7:0] cnt_val = '0;
  logic       cnt_top = 1'b0;
  logic       cnt_bottom = 1'b0;
  logic       cnt_wr = 1'b0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic       force_stb = 1'b0;
  logic [1:0] wave_mode = 2'b00;
  logic [1:0] out_mode = 2'b00;
  logic       flag_clr = 1'b0;
  logic       irq_ack = 1'b0;
  logic       cmp_flag;
  logic       wave_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tcmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
    .cnt_top(cnt_top), .cnt_bottom(cnt_bottom), .cnt_wr(cnt_wr),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .force_stb(force_stb),
    .wave_mode(wave_mode), .out_mode(out_mode), .flag_clr(flag_clr),
    .irq_ack(irq_ack), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  // {out_mode[1:0], use_force, expected pin, expected flag}; compare value 5
  localparam logic [4:0] VEC [8] = '{
    5'b11_0_1_1, 5'b01_0_0_1, 5'b01_1_1_0, 5'b10_1_0_0,
    5'b11_1_1_0, 5'b00_0_1_1, 5'b10_0_0_1, 5'b00_1_0_0
  };

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  // One clock edge with the inputs set by the caller, then strobes drop.
  task automatic step();
    @(negedge clk);
    tick_en = 0; cnt_wr = 0; cmp_wr = 0; force_stb = 0;
    flag_clr = 0; irq_ack = 0; cnt_top = 0; cnt_bottom = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", cmp_flag, 1'b0);
    chk("R1 pin", wave_out, 1'b0);
    tick_en = 1; cnt_val = 0; step();
    chk("R1 compare zero", cmp_flag, 1'b1);
    clear_flag();

    // R4: immediate write in normal mode
    wave_mode = 2'b00; cmp_wr = 1; cmp_wdata = 5; step();
    tick_en = 1; cnt_val = 5; step();
    chk("R4 direct write", cmp_flag, 1'b1);
    chk("R2 match flag", cmp_flag, 1'b1);
    clear_flag();

    // Table: R3 pin actions, R6 forced compares
    for (int i = 0; i < 8; i++) begin
      out_mode = VEC[i][4:3];
      if (VEC[i][2]) force_stb = 1;
      else begin tick_en = 1; cnt_val = 5; end
      step();
      chk(VEC[i][2] ? "R6 force pin" : "R3 match pin", wave_out, VEC[i][1]);
      chk(VEC[i][2] ? "R6 force no flag" : "R2 match flag", cmp_flag, VEC[i][0]);
      clear_flag();
    end

    // R5: PWM reload at top
    out_mode = 2'b00; wave_mode = 2'b10;
    cmp_wr = 1; cmp_wdata = 20; step();
    tick_en = 1; cnt_val = 20; step();
    chk("R5 shadow not active", cmp_flag, 1'b0);
    tick_en = 1; cnt_val = 0; cnt_bottom = 1; step();
    tick_en = 1; cnt_val = 20; step();
    chk("R5 bottom no reload in top mode", cmp_flag, 1'b0);
    tick_en = 1; cnt_val = 0; cnt_top = 1; step();
    tick_en = 1; cnt_val = 20; step();
    chk("R5 reload at top", cmp_flag, 1'b1);
    clear_flag();

    // R7: force ignored in PWM
    out_mode = 2'b01; force_stb = 1; step();
    chk("R7 pin", wave_out, 1'b0);
    chk("R7 flag", cmp_flag, 1'b0);

    // R5: PWM reload at bottom
    out_mode = 2'b00; wave_mode = 2'b11;
    cmp_wr = 1; cmp_wdata = 40; step();
    tick_en = 1; cnt_val = 40; step();
    chk("R5 shadow not active bottom", cmp_flag, 1'b0);
    tick_en = 1; cnt_val = 0; cnt_bottom = 1; step();
    tick_en = 1; cnt_val = 40; step();
    chk("R5 reload at bottom", cmp_flag, 1'b1);
    clear_flag();

    // R6: force coinciding with a real match toggles once
    wave_mode = 2'b01; cmp_wr = 1; cmp_wdata = 5; step();
    out_mode = 2'b01; force_stb = 1; tick_en = 1; cnt_val = 5; step();
    chk("R6 single toggle", wave_out, 1'b1);
    clear_flag();
    out_mode = 2'b00;

    // R10: no tick, no match
    wave_mode = 2'b00; cmp_wr = 1; cmp_wdata = 30; step();
    cnt_val = 30; step();
    chk("R10 no tick", cmp_flag, 1'b0);

    // R8: block survives stopped clock, only one tick suppressed
    cnt_wr = 1; step();
    repeat (5) step();
    tick_en = 1; cnt_val = 30; step();
    chk("R8 blocked tick", cmp_flag, 1'b0);
    tick_en = 1; cnt_val = 30; step();
    chk("R8 next tick matches", cmp_flag, 1'b1);

    // R9: sticky, set wins, ack clears
    repeat (4) step();
    chk("R9 sticky", cmp_flag, 1'b1);
    flag_clr = 1; tick_en = 1; cnt_val = 30; step();
    chk("R9 set wins", cmp_flag, 1'b1);
    irq_ack = 1; step();
    chk("R9 ack clears", cmp_flag, 1'b0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule